// File: doc/BRIEF.md
# Write-Completion Poll Engine

This block sits on the host side of a parallel flash and decides when a program or erase that the host has just issued has finished. Once started, it counts the host's command write strobes until the last one of the sequence has gone out. It then either reads a status location again and again through a request/acknowledge read port, or watches a ready/busy input. Each mode has its own completion test, and the result is a one-cycle pulse: done, timeout or rejected.

Three modes are offered. Toggle mode compares the toggle bit of consecutive reads. Data-polling mode compares the polling bit with the value it takes once the write has ended. Ready/busy mode only watches the pin. Status that flips at the very moment the write completes can look finished when it is not. To guard against this, a read-based pass is accepted only after two more reads of the same location also pass. A poll budget bounds the wait.

Top module: `wpoll_top`

## Requirements
- R1: A start (`startValid` high at a clock edge) is taken only while `startReady` is high, and `startReady` is high only when the engine is idle. A start presented while busy has no effect: no pulse, no change to the run in progress.
- R2: No status read is issued until the final command strobe has been seen. That is the 4th `wrStrobe` pulse for a program (`startErase`=0) and the 6th for an erase (`startErase`=1), counted from the cycle after the start is taken.
- R3: Toggle mode (`startMode`=00, and the spare code 11) compares bit 6 of each read with bit 6 of the previous read in the same run. A read passes when the two are equal. The first read of a run never passes.
- R4: Data-polling mode (`startMode`=01) compares bit 7 of each read with a target. For a program the target is `startExpBit`, and for an erase it is 1, whatever `startExpBit` holds.
- R5: Completion requires one passing read followed by two further passing reads of the same address. Any failing read sets this count back to zero. The minimum is therefore 4 reads in toggle mode and 3 in data-polling mode.
- R6: A start with `startSecId`=1 in data-polling mode is refused. `rejectPulse` is high in the cycle after the start edge, no read is issued and the engine stays idle. Toggle mode with `startSecId`=1 runs normally.
- R7: Each status read, and each ready/busy wait cycle, uses one unit of the `pollLimit` budget. If the poll that exhausts the budget does not complete the run, `timeoutPulse` fires. If that same poll completes the run, `donePulse` fires instead.
- R8: Ready/busy mode (`startMode`=10) issues no reads. It completes once `rdyBusy` has been sampled high on two consecutive clock edges after the final strobe.
- R9: `donePulse`, `timeoutPulse` and `rejectPulse` each last one cycle, and at most one is high at a time. A read-mode result appears in the cycle after the edge that follows the acknowledged final read.
- R10: `rdReq` stays high until `rdAck` is seen, and `rdAddr` holds the start address throughout the run.
- R11: After reset the engine is idle: `startReady`=1, `rdReq`=0 and all result pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start request |
| startReady | output | 1 | High while idle; a start is taken only then |
| startMode | input | 2 | 00 toggle, 01 data-polling, 10 ready/busy, 11 toggle |
| startErase | input | 1 | 1 = erase sequence (6 strobes), 0 = program (4 strobes) |
| startSecId | input | 1 | Security-ID programming; only toggle mode is allowed |
| startExpBit | input | 1 | True bit 7 of the programmed data |
| startAddr | input | ADDR_W | Status location to poll |
| pollLimit | input | CNT_W | Poll budget for the run |
| wrStrobe | input | 1 | One-cycle pulse for each command write the host issues |
| rdReq | output | 1 | Read request, held until acknowledged |
| rdAddr | output | ADDR_W | Read address |
| rdAck | input | 1 | Read acknowledge; `rdData` is valid in the same cycle |
| rdData | input | DATA_W | Read data |
| rdyBusy | input | 1 | Ready (1) / busy (0) level |
| donePulse | output | 1 | Write completed |
| timeoutPulse | output | 1 | Poll budget used up |
| rejectPulse | output | 1 | Start refused |

## Verification
Every result is registered. A read-mode result is due one edge after the edge that took the final read's acknowledge. A ready/busy result is due at the edge that takes the second consecutive high sample. A refusal is due at the start edge itself. The bench drives and samples only on falling edges and records the edge of each acknowledged read. It then checks that the pulse shows up exactly one sample after it, and that the pulse has gone at the next sample. For the gating and ready/busy cases it counts sample points from the last strobe and checks that no result or request comes early.

// File: rtl/wpoll_pkg.sv
`timescale 1ns/1ps
package wpoll_pkg;

  typedef enum logic [1:0] {
    MODE_TOGGLE = 2'b00,
    MODE_DPOLL  = 2'b01,
    MODE_RDYBSY = 2'b10,
    MODE_SPARE  = 2'b11
  } pollMode_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SEQ    = 3'd1,
    ST_READ   = 3'd2,
    ST_EVAL   = 3'd3,
    ST_RBWAIT = 3'd4
  } pollState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic seqInc;
    logic capture;
    logic evalUpd;
    logic pollTick;
    logic rbSample;
  } dpCtrl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic rejectCfg;
    logic seqLast;
    logic seqReached;
    logic isRb;
    logic confirmHit;
    logic limitHit;
    logic rbConfirm;
  } dpFlags_t;

endpackage

// File: rtl/wpoll_dp.sv
`timescale 1ns/1ps
module wpoll_dp
  import wpoll_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int ADDR_W        = 22,
  parameter int CNT_W         = 16,
  parameter int TOGGLE_BIT    = 6,
  parameter int POLL_BIT      = 7,
  parameter int PROG_STROBES  = 4,
  parameter int ERASE_STROBES = 6,
  parameter int CONFIRM_READS = 2,
  parameter bit HAS_RDYBSY    = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [1:0]        startMode,
  input  logic              startErase,
  input  logic              startSecId,
  input  logic              startExpBit,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  pollLimit,
  input  logic [DATA_W-1:0] rdData,
  input  logic              rdyBusy,
  output logic [ADDR_W-1:0] rdAddr,
  output dpFlags_t          flags
);

  localparam int SEQ_W  = $clog2(ERASE_STROBES + 1);
  localparam int PASS_W = $clog2(CONFIRM_READS + 1);
  localparam logic [SEQ_W-1:0]  PROG_N  = SEQ_W'(PROG_STROBES);
  localparam logic [SEQ_W-1:0]  ERASE_N = SEQ_W'(ERASE_STROBES);
  localparam logic [PASS_W-1:0] PASS_N  = PASS_W'(CONFIRM_READS);

  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  limitQ;
  pollMode_e         modeQ;
  logic              eraseQ;
  logic              expQ;
  logic [SEQ_W-1:0]  seqCnt;
  logic              sampleTog;
  logic              samplePol;
  logic              prevTog;
  logic              havePrev;
  logic [PASS_W-1:0] passCnt;
  logic [CNT_W-1:0]  pollCnt;
  logic              rbHigh;
  logic              rbAllowed;

  logic [SEQ_W-1:0]  seqNeed;
  logic              isToggle;
  logic              targetBit;
  logic              readPass;
  logic [CNT_W:0]    pollNext;
  logic              unusedBits;

  assign unusedBits = ^rdData;

  // configuration captured when a run is accepted
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      limitQ <= '0;
      modeQ  <= MODE_TOGGLE;
      eraseQ <= 1'b0;
      expQ   <= 1'b0;
    end else if (ctrl.loadCfg) begin
      addrQ  <= startAddr;
      limitQ <= pollLimit;
      modeQ  <= pollMode_e'(startMode);
      eraseQ <= startErase;
      expQ   <= startExpBit;
    end
  end

  assign rdAddr  = addrQ;
  assign seqNeed = eraseQ ? ERASE_N : PROG_N;

  // command strobe counter
  always_ff @(posedge clk) begin
    if (!rstN)              seqCnt <= '0;
    else if (ctrl.loadCfg)  seqCnt <= '0;
    else if (ctrl.seqInc)   seqCnt <= seqCnt + 1'b1;
  end

  // captured status bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleTog <= 1'b0;
      samplePol <= 1'b0;
    end else if (ctrl.capture) begin
      sampleTog <= rdData[TOGGLE_BIT];
      samplePol <= rdData[POLL_BIT];
    end
  end

  assign isToggle  = (modeQ != MODE_DPOLL);
  assign targetBit = eraseQ ? 1'b1 : expQ;
  assign readPass  = isToggle ? (havePrev && (sampleTog == prevTog))
                              : (samplePol == targetBit);

  // consecutive pass counter and previous toggle sample
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevTog  <= 1'b0;
      havePrev <= 1'b0;
      passCnt  <= '0;
    end else if (ctrl.loadCfg) begin
      prevTog  <= 1'b0;
      havePrev <= 1'b0;
      passCnt  <= '0;
    end else if (ctrl.evalUpd) begin
      prevTog  <= sampleTog;
      havePrev <= 1'b1;
      passCnt  <= (readPass && (passCnt != PASS_N)) ? passCnt + 1'b1 : '0;
    end
  end

  // poll budget counter
  assign pollNext = {1'b0, pollCnt} + (CNT_W+1)'(1);

  always_ff @(posedge clk) begin
    if (!rstN)                                 pollCnt <= '0;
    else if (ctrl.loadCfg)                     pollCnt <= '0;
    else if (ctrl.pollTick && !(&pollCnt))     pollCnt <= pollNext[CNT_W-1:0];
  end

  // optional ready/busy sampling path
  generate
    if (HAS_RDYBSY) begin : g_rb
      always_ff @(posedge clk) begin
        if (!rstN)              rbHigh <= 1'b0;
        else if (ctrl.loadCfg)  rbHigh <= 1'b0;
        else if (ctrl.rbSample) rbHigh <= rdyBusy;
      end
      assign rbAllowed = 1'b1;
    end else begin : g_norb
      assign rbHigh    = 1'b0;
      assign rbAllowed = 1'b0;
    end
  endgenerate

  always_comb begin
    flags            = '0;
    flags.rejectCfg  = ((startMode == MODE_DPOLL) && startSecId) ||
                       ((startMode == MODE_RDYBSY) && !rbAllowed);
    flags.seqLast    = (seqCnt == seqNeed - 1'b1);
    flags.seqReached = (seqCnt >= seqNeed);
    flags.isRb       = (modeQ == MODE_RDYBSY);
    flags.confirmHit = readPass && (passCnt == PASS_N);
    flags.limitHit   = (pollNext >= {1'b0, limitQ});
    flags.rbConfirm  = rdyBusy && rbHigh;
  end

  AST_PASS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    passCnt <= PASS_N);                                               // R5
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (limitQ != '0) |-> (pollCnt <= limitQ));                          // R7
  AST_SEQ_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    seqCnt <= ERASE_N);                                               // R2

endmodule

// File: rtl/wpoll_ctrl.sv
`timescale 1ns/1ps
module wpoll_ctrl
  import wpoll_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startValid,
  input  logic     wrStrobe,
  input  logic     rdAck,
  input  dpFlags_t flags,
  output logic     startReady,
  output logic     rdReq,
  output logic     donePulse,
  output logic     timeoutPulse,
  output logic     rejectPulse,
  output dpCtrl_t  ctrl
);

  pollState_e state;
  pollState_e nextState;
  logic       pollPhase;
  logic       doneNext;
  logic       timeoutNext;
  logic       rejectNext;

  always_comb begin
    nextState = state;
    ctrl      = '0;
    case (state)
      ST_IDLE: begin
        if (startValid && !flags.rejectCfg) begin
          ctrl.loadCfg = 1'b1;
          nextState    = ST_SEQ;
        end
      end
      ST_SEQ: begin
        if (wrStrobe) begin
          ctrl.seqInc = 1'b1;
          if (flags.seqLast) nextState = flags.isRb ? ST_RBWAIT : ST_READ;
        end
      end
      ST_READ: begin
        if (rdAck) begin
          ctrl.capture = 1'b1;
          nextState    = ST_EVAL;
        end
      end
      ST_EVAL: begin
        ctrl.evalUpd  = 1'b1;
        ctrl.pollTick = 1'b1;
        nextState     = (flags.confirmHit || flags.limitHit) ? ST_IDLE : ST_READ;
      end
      ST_RBWAIT: begin
        ctrl.rbSample = 1'b1;
        ctrl.pollTick = 1'b1;
        if (flags.rbConfirm || flags.limitHit) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign pollPhase   = (state == ST_EVAL) || (state == ST_RBWAIT);
  assign doneNext    = ((state == ST_EVAL) && flags.confirmHit) ||
                       ((state == ST_RBWAIT) && flags.rbConfirm);
  assign timeoutNext = pollPhase && !doneNext && flags.limitHit;
  assign rejectNext  = (state == ST_IDLE) && startValid && flags.rejectCfg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      donePulse    <= 1'b0;
      timeoutPulse <= 1'b0;
      rejectPulse  <= 1'b0;
    end else begin
      state        <= nextState;
      donePulse    <= doneNext;
      timeoutPulse <= timeoutNext;
      rejectPulse  <= rejectNext;
    end
  end

  assign startReady = (state == ST_IDLE);
  assign rdReq      = (state == ST_READ);

  AST_RESULT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({donePulse, timeoutPulse, rejectPulse}));                // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);                                        // R9
  AST_TIMEOUT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse);                                  // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck) |=> rdReq);                                     // R10
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && !startReady) |=> !rejectPulse);                    // R1

endmodule

// File: rtl/wpoll_top.sv
`timescale 1ns/1ps
module wpoll_top
  import wpoll_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int ADDR_W        = 22,
  parameter int CNT_W         = 16,
  parameter int TOGGLE_BIT    = 6,
  parameter int POLL_BIT      = 7,
  parameter int PROG_STROBES  = 4,
  parameter int ERASE_STROBES = 6,
  parameter int CONFIRM_READS = 2,
  parameter bit HAS_RDYBSY    = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  output logic              startReady,
  input  logic [1:0]        startMode,
  input  logic              startErase,
  input  logic              startSecId,
  input  logic              startExpBit,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  pollLimit,
  input  logic              wrStrobe,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdAck,
  input  logic [DATA_W-1:0] rdData,
  input  logic              rdyBusy,
  output logic              donePulse,
  output logic              timeoutPulse,
  output logic              rejectPulse
);

  dpCtrl_t  ctrl;
  dpFlags_t flags;

  wpoll_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startValid   (startValid),
    .wrStrobe     (wrStrobe),
    .rdAck        (rdAck),
    .flags        (flags),
    .startReady   (startReady),
    .rdReq        (rdReq),
    .donePulse    (donePulse),
    .timeoutPulse (timeoutPulse),
    .rejectPulse  (rejectPulse),
    .ctrl         (ctrl)
  );

  wpoll_dp #(
    .DATA_W        (DATA_W),
    .ADDR_W        (ADDR_W),
    .CNT_W         (CNT_W),
    .TOGGLE_BIT    (TOGGLE_BIT),
    .POLL_BIT      (POLL_BIT),
    .PROG_STROBES  (PROG_STROBES),
    .ERASE_STROBES (ERASE_STROBES),
    .CONFIRM_READS (CONFIRM_READS),
    .HAS_RDYBSY    (HAS_RDYBSY)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .startMode   (startMode),
    .startErase  (startErase),
    .startSecId  (startSecId),
    .startExpBit (startExpBit),
    .startAddr   (startAddr),
    .pollLimit   (pollLimit),
    .rdData      (rdData),
    .rdyBusy     (rdyBusy),
    .rdAddr      (rdAddr),
    .flags       (flags)
  );

  AST_SEQ_BEFORE_READ: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> flags.seqReached);                                      // R2
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && $past(rdReq)) |-> $stable(rdAddr));                     // R10
  AST_REJECT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    rejectPulse |-> $past(startValid && startReady && startSecId &&
                          (startMode == MODE_DPOLL)));                // R6

endmodule

// File: tb/test_wpoll_top.sv
`timescale 1ns/1ps
module test_wpoll_top;

  localparam int DW = 16;
  localparam int AW = 22;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startValid = 1'b0;
  logic          startReady;
  logic [1:0]    startMode = 2'b00;
  logic          startErase = 1'b0;
  logic          startSecId = 1'b0;
  logic          startExpBit = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic [CW-1:0] pollLimit = '0;
  logic          wrStrobe = 1'b0;
  logic          rdReq;
  logic [AW-1:0] rdAddr;
  logic          rdAck;
  logic [DW-1:0] rdData;
  logic          rdyBusy = 1'b0;
  logic          donePulse;
  logic          timeoutPulse;
  logic          rejectPulse;

  int            cmpCnt = 0;
  int            misCnt = 0;
  int            cyc = 0;
  int            rdIdx = 0;
  int            lastAck = 0;
  int            base = 0;
  logic          ackEn = 1'b1;
  logic [DW-1:0] script [16];

  always #2.5 clk = ~clk;

  wpoll_top i_wpoll_top (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startReady(startReady),
    .startMode(startMode), .startErase(startErase), .startSecId(startSecId),
    .startExpBit(startExpBit), .startAddr(startAddr), .pollLimit(pollLimit),
    .wrStrobe(wrStrobe), .rdReq(rdReq), .rdAddr(rdAddr), .rdAck(rdAck),
    .rdData(rdData), .rdyBusy(rdyBusy), .donePulse(donePulse),
    .timeoutPulse(timeoutPulse), .rejectPulse(rejectPulse)
  );

  // simple status memory model
  assign rdAck  = rdReq & ackEn;
  assign rdData = script[(rdIdx - base) & 15];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rdReq && rdAck) begin
      rdIdx   <= rdIdx + 1;
      lastAck <= cyc + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    cmpCnt++;
    if (act != exp) begin
      misCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, misCnt);
  endtask

  task automatic fillScript(input logic [DW-1:0] v);
    for (int i = 0; i < 16; i++) script[i] = v;
  endtask

  task automatic doStart(input logic [1:0] mode, input bit erase, input bit secId,
                         input bit expBit, input int limit, input int addr);
    @(negedge clk);
    startMode   = mode;
    startErase  = erase;
    startSecId  = secId;
    startExpBit = expBit;
    startAddr   = AW'(addr);
    pollLimit   = CW'(limit);
    startValid  = 1'b1;
    @(negedge clk);
    startValid  = 1'b0;
  endtask

  task automatic doStrobes(input int n);
    for (int i = 0; i < n; i++) begin
      wrStrobe = 1'b1;
      @(negedge clk);
      wrStrobe = 1'b0;
    end
  endtask

  // kind: 1 done, 2 timeout, 3 reject, 0 none
  task automatic waitRes(output int kind, output int at);
    kind = 0;
    at   = 0;
    for (int i = 0; i < 300; i++) begin
      if (donePulse || timeoutPulse || rejectPulse) begin
        kind = donePulse ? 1 : (timeoutPulse ? 2 : 3);
        at   = cyc;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic afterPulse(input string req);
    @(negedge clk);
    chk(req, "pulses clear next cycle", int'({donePulse, timeoutPulse, rejectPulse}), 0);
    chk(req, "idle after result", int'(startReady), 1);
  endtask

  task automatic runRead(input string req, input logic [1:0] mode, input bit erase,
                         input bit expBit, input int limit, input int expKind,
                         input int expReads);
    int kind;
    int at;
    base = rdIdx;
    doStart(mode, erase, 1'b0, expBit, limit, 24'h1234);
    doStrobes(erase ? 6 : 4);
    waitRes(kind, at);
    chk(req, "result kind", kind, expKind);
    chk(req, "reads issued", rdIdx - base, expReads);
    chk("R9", "latency from last ack", at - lastAck, 1);
    afterPulse("R9");
  endtask

  task automatic t_reset();
    chk("R11", "startReady", int'(startReady), 1);
    chk("R11", "rdReq", int'(rdReq), 0);
    chk("R11", "pulses", int'({donePulse, timeoutPulse, rejectPulse}), 0);
  endtask

  task automatic t_toggle_basic();
    fillScript(16'h0040);
    script[1] = 16'h0000;
    runRead("R3", 2'b00, 1'b0, 1'b0, 100, 1, 6);
  endtask

  task automatic t_toggle_spurious();
    fillScript(16'h0040);
    script[0] = 16'h0000;
    script[1] = 16'h0000;
    runRead("R5", 2'b00, 1'b0, 1'b0, 100, 1, 6);
    // spare code acts as toggle, minimum 4 reads, bit 7 noise ignored
    fillScript(16'h0040);
    script[2] = 16'h00C0;
    runRead("R5", 2'b11, 1'b0, 1'b0, 100, 1, 4);
  endtask

  task automatic t_dpoll();
    fillScript(16'h0080);
    script[0] = 16'h0000;
    runRead("R4", 2'b01, 1'b0, 1'b1, 100, 1, 4);
    fillScript(16'h0000);
    script[0] = 16'h0080;
    runRead("R4", 2'b01, 1'b0, 1'b0, 100, 1, 4);
    // erase target is 1 despite expBit 0
    fillScript(16'h0080);
    script[0] = 16'h0000;
    script[2] = 16'h0000;
    runRead("R4", 2'b01, 1'b1, 1'b0, 100, 1, 6);
    // minimum 3 reads in data-polling
    fillScript(16'h0080);
    runRead("R5", 2'b01, 1'b0, 1'b1, 100, 1, 3);
  endtask

  task automatic t_secid();
    int kind;
    int at;
    base = rdIdx;
    doStart(2'b01, 1'b0, 1'b1, 1'b1, 100, 24'h0555);
    // doStart returns at the sample after the start edge
    chk("R6", "reject pulse", int'(rejectPulse), 1);
    chk("R6", "still idle", int'(startReady), 1);
    afterPulse("R6");
    doStrobes(4);
    repeat (3) @(negedge clk);
    chk("R6", "no reads after reject", rdIdx - base, 0);
    chk("R6", "no request after reject", int'(rdReq), 0);
    // toggle with security-ID is accepted
    fillScript(16'h0040);
    base = rdIdx;
    doStart(2'b00, 1'b0, 1'b1, 1'b0, 100, 24'h0555);
    chk("R6", "toggle+secid not rejected", int'(rejectPulse), 0);
    doStrobes(4);
    waitRes(kind, at);
    chk("R6", "toggle+secid done", kind, 1);
    chk("R6", "toggle+secid reads", rdIdx - base, 4);
    afterPulse("R6");
  endtask

  task automatic t_timeout();
    for (int i = 0; i < 16; i++) script[i] = (i % 2 == 1) ? 16'h0040 : 16'h0000;
    runRead("R7", 2'b00, 1'b0, 1'b0, 3, 2, 3);
    fillScript(16'h0040);
    runRead("R7", 2'b00, 1'b0, 1'b0, 3, 2, 3);
    fillScript(16'h0040);
    runRead("R7", 2'b00, 1'b0, 1'b0, 4, 1, 4);
  endtask

  task automatic t_gate_hold();
    int kind;
    int at;
    fillScript(16'h0040);
    base  = rdIdx;
    ackEn = 1'b0;
    doStart(2'b00, 1'b0, 1'b0, 1'b0, 100, 24'h2A5A5);
    doStrobes(3);
    repeat (4) @(negedge clk);
    chk("R2", "no request before 4th strobe", int'(rdReq), 0);
    doStrobes(1);
    chk("R2", "request after 4th strobe", int'(rdReq), 1);
    chk("R1", "not ready while busy", int'(startReady), 0);
    // start while busy: would be refused if taken
    startMode  = 2'b01;
    startSecId = 1'b1;
    startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    chk("R1", "busy start gives no reject", int'(rejectPulse), 0);
    @(negedge clk);
    chk("R10", "request held without ack", int'(rdReq), 1);
    chk("R10", "address held", int'(rdAddr), 32'h2A5A5);
    ackEn = 1'b1;
    waitRes(kind, at);
    chk("R1", "run unaffected by busy start", kind, 1);
    chk("R1", "reads of unaffected run", rdIdx - base, 4);
    afterPulse("R9");
    // erase gating: 6 strobes
    fillScript(16'h0040);
    base = rdIdx;
    doStart(2'b00, 1'b1, 1'b0, 1'b0, 100, 24'h0100);
    doStrobes(5);
    repeat (3) @(negedge clk);
    chk("R2", "no request before 6th strobe", rdIdx - base, 0);
    doStrobes(1);
    waitRes(kind, at);
    chk("R2", "erase run done", kind, 1);
    afterPulse("R9");
  endtask

  task automatic t_rdybusy();
    logic pat [5];
    base   = rdIdx;
    pat[0] = 1'b0; pat[1] = 1'b1; pat[2] = 1'b0; pat[3] = 1'b1; pat[4] = 1'b1;
    rdyBusy = 1'b0;
    doStart(2'b10, 1'b0, 1'b0, 1'b0, 100, 24'h0);
    doStrobes(4);
    for (int i = 0; i < 5; i++) begin
      chk("R8", "no early result", int'({donePulse, timeoutPulse}), 0);
      rdyBusy = pat[i];
      @(negedge clk);
    end
    chk("R8", "done after two highs", int'(donePulse), 1);
    chk("R8", "no reads in ready/busy", rdIdx - base, 0);
    rdyBusy = 1'b0;
    afterPulse("R9");
    // ready/busy timeout after 5 wait cycles
    doStart(2'b10, 1'b0, 1'b0, 1'b0, 5, 24'h0);
    doStrobes(4);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R7", "no early timeout", int'(timeoutPulse), 0);
    end
    @(negedge clk);
    chk("R7", "ready/busy timeout", int'(timeoutPulse), 1);
    afterPulse("R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    cmpCnt++;
    misCnt++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    fillScript(16'h0000);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_toggle_basic();
    t_toggle_spurious();
    t_dpoll();
    t_secid();
    t_timeout();
    t_gate_hold();
    t_rdybusy();
    summary();
    $finish;
  end

endmodule